// File: doc/BRIEF.md
# Edge-Select External Interrupt Controller

This block watches five external interrupt pins and turns a chosen transition on each into a sticky request. Each pin is first passed through a synchroniser. A per-pin polarity bit then decides whether the unit reacts to the low-to-high or the high-to-low change of that pin. A detected transition latches a request flag. The flag stays set until software clears it.

A per-pin enable gates each flag onto one combined interrupt line. Flags latch even while their enable is off, so software can poll them. Software reaches the three registers through a plain synchronous bus with an address, write data, a write strobe and combinational read data. Request flags can be cleared by the bus but never set by it. Some bits of the polarity and flag registers are fixed constants.

Register selection uses `bus_addr`: 0 is the polarity register, 1 is the enable register, 2 is the request register, and 3 is unused.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset the polarity register reads 0x60, the enable register reads 0x00, the request register reads 0x20, and `irq_o` is low.
- R2: Polarity bit i (bits 4..0 at address 0) selects the transition that is detected on pin i. A value of 0 detects a falling edge and a value of 1 detects a rising edge. The other transition sets nothing.
- R3: In the polarity register, bit 7 always reads 0 and bits 6 and 5 always read 1. Writes to these three bits have no effect.
- R4: A detected transition on pin i sets request bit i (address 2). The pin value is sampled at a rising clock edge, and the flag is readable after the third rising edge from that one. The flag stays set after the pin returns to its old level.
- R5: A bus write to the request register clears every flag bit written as 0 and leaves every flag bit written as 1 unchanged. No write sets a flag. Bit 5 of this register always reads 1, and bits 7 and 6 always read 0.
- R6: If a transition is detected on a pin in the same cycle as a clearing write to its flag, the flag ends up set.
- R7: The enable register (address 1) holds bits 4..0, and its bits 7..5 read 0. `irq_o` is high exactly when some pin has both its request flag and its enable bit set. Flags latch whatever the enable is.
- R8: Changing a polarity bit while its pin is steady sets no request flag.
- R9: Address 3 reads as 0x00. A write to address 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 5 | External interrupt pins, asynchronous to clk |
| bus_addr | input | 2 | Register select |
| bus_we | input | 1 | Write strobe, captured at the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: five pins and a two-stage synchroniser. With these values the three-edge latency from pin to flag can be checked at exact cycles. They also make every bit of all three registers reachable, including the fixed bits at positions 7 to 5. Directed cases cover the following:
- reset values;
- writes to the fixed bits;
- the unused address;
- each polarity;
- clears written as 1 and as 0;
- a transition that coincides with a clearing write;
- polarity toggles while the pins are held steady.

A long random run then mixes pin activity with bus writes. After every cycle it compares both the readback and `irq_o` with a cycle model kept in the bench.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

   localparam int REG_W    = 8;
   localparam int MAX_PINS = 5;

   typedef enum logic [1:0] {
      SEL_POL  = 2'd0,
      SEL_EN   = 2'd1,
      SEL_FLAG = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   // constant bits that appear in readback
   localparam logic [REG_W-1:0] POL_ONES  = 8'h60;
   localparam logic [REG_W-1:0] FLAG_ONES = 8'h20;

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
   parameter int WIDTH  = 5,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   logic [WIDTH-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         $error("xirq_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/xirq_edge.sv
module xirq_edge #(
   parameter int WIDTH = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level,
   input  logic [WIDTH-1:0] rise_sel,
   output logic [WIDTH-1:0] prev,
   output logic [WIDTH-1:0] hit
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= level;
   end

   // only a real level change can produce a hit; polarity just picks which
   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         always_comb begin
            if (rise_sel[i]) hit[i] = level[i] & ~prev[i];
            else             hit[i] = ~level[i] & prev[i];
         end
      end
   endgenerate

endmodule

// File: rtl/xirq_flags.sv
module xirq_flags #(
   parameter int WIDTH = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] hit,
   input  logic             clr_we,
   input  logic [WIDTH-1:0] keep_mask,
   output logic [WIDTH-1:0] flag
);

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               flag[i] <= 1'b0;
            else if (hit[i])
               flag[i] <= 1'b1;           // hardware set wins over a clear
            else if (clr_we && !keep_mask[i])
               flag[i] <= 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
   import xirq_pkg::*;
#(
   parameter int NUM_PINS    = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] irq_pin,
   input  logic [1:0]          bus_addr,
   input  logic                bus_we,
   input  logic [REG_W-1:0]    bus_wdata,
   output logic [REG_W-1:0]    bus_rdata,
   output logic                irq_o
);

   localparam logic [REG_W-1:0] PIN_MASK = REG_W'((1 << NUM_PINS) - 1);

   generate
      if (NUM_PINS < 1 || NUM_PINS > MAX_PINS) begin : g_chk_pins
         $error("xirq_ctrl: NUM_PINS out of range");
      end
      if ((PIN_MASK & (POL_ONES | FLAG_ONES)) != '0) begin : g_chk_fixed
         $error("xirq_ctrl: pin bits overlap fixed bits");
      end
   endgenerate

   logic [REG_W-1:0]    pol_q;
   logic [REG_W-1:0]    en_q;
   logic [NUM_PINS-1:0] sync_cur;
   logic [NUM_PINS-1:0] prev;
   logic [NUM_PINS-1:0] hit;
   logic [NUM_PINS-1:0] flag_q;
   logic                wr_pol, wr_en, wr_flag;

   assign wr_pol  = bus_we && (bus_addr == SEL_POL);
   assign wr_en   = bus_we && (bus_addr == SEL_EN);
   assign wr_flag = bus_we && (bus_addr == SEL_FLAG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q <= '0;
         en_q  <= '0;
      end else begin
         if (wr_pol) pol_q <= bus_wdata & PIN_MASK;
         if (wr_en)  en_q  <= bus_wdata & PIN_MASK;
      end
   end

   xirq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (irq_pin),
      .sync_out (sync_cur)
   );

   xirq_edge #(.WIDTH(NUM_PINS)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .level    (sync_cur),
      .rise_sel (pol_q[NUM_PINS-1:0]),
      .prev     (prev),
      .hit      (hit)
   );

   xirq_flags #(.WIDTH(NUM_PINS)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (hit),
      .clr_we    (wr_flag),
      .keep_mask (bus_wdata[NUM_PINS-1:0]),
      .flag      (flag_q)
   );

   always_comb begin
      unique case (reg_sel_e'(bus_addr))
         SEL_POL:  bus_rdata = pol_q | POL_ONES;
         SEL_EN:   bus_rdata = en_q;
         SEL_FLAG: bus_rdata = REG_W'(flag_q) | FLAG_ONES;
         default:  bus_rdata = '0;
      endcase
   end

   assign irq_o = |(flag_q & en_q[NUM_PINS-1:0]);

endmodule

// File: rtl/xirq_ctrl_chk.sv
module xirq_ctrl_chk
   import xirq_pkg::*;
#(
   parameter int NUM_PINS = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic [1:0]          bus_addr,
   input logic                bus_we,
   input logic [REG_W-1:0]    bus_wdata,
   input logic [REG_W-1:0]    bus_rdata,
   input logic                irq_o,
   input logic [REG_W-1:0]    en_q,
   input logic [NUM_PINS-1:0] flag_q,
   input logic [NUM_PINS-1:0] hit,
   input logic [NUM_PINS-1:0] sync_cur,
   input logic [NUM_PINS-1:0] prev
);

   localparam logic [REG_W-1:0] PIN_MASK = REG_W'((1 << NUM_PINS) - 1);

   // R3: fixed polarity bits
   p_pol_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == SEL_POL) |-> ((bus_rdata & ~PIN_MASK) == POL_ONES));

   // R5: fixed request bits
   p_flag_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == SEL_FLAG) |-> ((bus_rdata & ~PIN_MASK) == FLAG_ONES));

   // R5: a flag only rises after an edge hit
   p_flag_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(hit)) == '0));

   // R5: bits written as 0 are clear unless a hit arrived
   p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == SEL_FLAG) |=>
         ((flag_q & ~$past(bus_wdata[NUM_PINS-1:0]) & ~$past(hit)) == '0));

   // R6: a hit always leaves its flag set
   p_hit_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit != '0) |=> ((flag_q & $past(hit)) == $past(hit)));

   // R7: no enabled flag, no interrupt
   p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_q & en_q[NUM_PINS-1:0]) == '0) |-> !irq_o);

   // R8: a steady synchronised level never yields a hit
   p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_cur == prev) |-> (hit == '0));

   // R9: unused address reads zero
   p_hole_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == SEL_NONE) |-> (bus_rdata == '0));

endmodule

bind xirq_ctrl xirq_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq_o     (irq_o),
   .en_q      (en_q),
   .flag_q    (flag_q),
   .hit       (hit),
   .sync_cur  (sync_cur),
   .prev      (prev)
);

// File: tb/xirq_ctrl_tb.sv
module xirq_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NP = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] irq_pin = '0;
   logic [1:0]    bus_addr = 2'd0;
   logic          bus_we = 1'b0;
   logic [7:0]    bus_wdata = 8'h00;
   logic [7:0]    bus_rdata;
   logic          irq_o;

   int total = 0;
   int bad   = 0;

   // bench model of the specified behaviour
   logic [7:0]    m_pol, m_en, m_flag;
   logic [NP-1:0] m_s1, m_s2, m_pv;

   always #(CLK_PERIOD/2) clk = ~clk;

   xirq_ctrl u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_pin   (irq_pin),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o)
   );

   function automatic logic [7:0] exp_read(input logic [1:0] a);
      case (a)
         2'd0:    return m_pol | 8'h60;
         2'd1:    return m_en;
         2'd2:    return (m_flag & 8'h1F) | 8'h20;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic exp_irq();
      return |(m_flag & m_en & 8'h1F);
   endfunction

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
      end
   endtask

   // read register a at the current negedge and compare to a literal
   task automatic rd(input string tag, input logic [1:0] a, input logic [7:0] exp);
      bus_we = 1'b0;
      bus_addr = a;
      #1;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic chk_irq(input string tag, input logic exp);
      #1;
      chk(tag, {7'd0, irq_o}, {7'd0, exp});
   endtask

   // one clock: drive, advance the model at the edge, return at negedge
   task automatic tick(input logic we, input logic [1:0] a,
                       input logic [7:0] wd, input logic [NP-1:0] pins);
      logic [NP-1:0] e;
      logic [7:0]    nf;
      bus_we = we; bus_addr = a; bus_wdata = wd; irq_pin = pins;
      for (int i = 0; i < NP; i++)
         e[i] = m_pol[i] ? (m_s2[i] & ~m_pv[i]) : (~m_s2[i] & m_pv[i]);
      nf = (we && a == 2'd2) ? (m_flag & wd) : m_flag;
      nf = (nf | {3'd0, e}) & 8'h1F;
      @(posedge clk);
      m_pv = m_s2; m_s2 = m_s1; m_s1 = pins;
      m_flag = nf;
      if (we && a == 2'd0) m_pol = wd & 8'h1F;
      if (we && a == 2'd1) m_en  = wd & 8'h1F;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) tick(1'b0, 2'd0, 8'h00, irq_pin);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      m_pol = 0; m_en = 0; m_flag = 0; m_s1 = 0; m_s2 = 0; m_pv = 0;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd("R1 pol", 2'd0, 8'h60);
      rd("R1 en", 2'd1, 8'h00);
      rd("R1 flag", 2'd2, 8'h20);
      chk_irq("R1 irq", 1'b0);

      // R3 fixed polarity bits
      tick(1'b1, 2'd0, 8'hFF, '0);
      rd("R3 pol all ones", 2'd0, 8'h7F);
      tick(1'b1, 2'd0, 8'h80, '0);
      rd("R3 pol top bit", 2'd0, 8'h60);

      // R9 unused address
      tick(1'b1, 2'd3, 8'hFF, '0);
      rd("R9 hole", 2'd3, 8'h00);
      rd("R9 en untouched", 2'd1, 8'h00);
      rd("R9 pol untouched", 2'd0, 8'h60);
      rd("R9 flag untouched", 2'd2, 8'h20);

      // R2 falling mode ignores rising
      tick(1'b0, 2'd0, 8'h00, 5'h1F);
      idle(4);
      rd("R2 rise ignored in falling mode", 2'd2, 8'h20);
      // R4 latency: fall sampled at first edge, flag after third
      tick(1'b0, 2'd0, 8'h00, 5'h00);
      tick(1'b0, 2'd0, 8'h00, 5'h00);
      rd("R4 not yet after two edges", 2'd2, 8'h20);
      tick(1'b0, 2'd0, 8'h00, 5'h00);
      rd("R4 set after three edges", 2'd2, 8'h3F);
      idle(3);
      rd("R4 sticky", 2'd2, 8'h3F);

      // R7 enable gating with flags already set
      chk_irq("R7 disabled no irq", 1'b0);
      tick(1'b1, 2'd1, 8'hE4, '0);
      rd("R7 en readback", 2'd1, 8'h04);
      chk_irq("R7 irq on", 1'b1);

      // R5 clearing
      tick(1'b1, 2'd2, 8'hFF, '0);
      rd("R5 write ones keeps", 2'd2, 8'h3F);
      tick(1'b1, 2'd2, 8'hFB, '0);
      rd("R5 clear bit2", 2'd2, 8'h3B);
      chk_irq("R7 irq off after clear", 1'b0);
      tick(1'b1, 2'd2, 8'h00, '0);
      rd("R5 clear all", 2'd2, 8'h20);

      // R2 rising mode on pin 0
      tick(1'b1, 2'd0, 8'h01, '0);
      tick(1'b0, 2'd0, 8'h00, 5'h01);
      idle(3);
      rd("R2 rising pin0", 2'd2, 8'h21);
      tick(1'b1, 2'd2, 8'h00, 5'h01);

      // R6 edge and clear in the same cycle
      tick(1'b0, 2'd0, 8'h00, 5'h00);   // pin0 falls -> no hit (rising mode)
      idle(3);
      tick(1'b0, 2'd0, 8'h00, 5'h01);   // rise sampled here
      tick(1'b0, 2'd0, 8'h00, 5'h01);
      tick(1'b1, 2'd2, 8'h00, 5'h01);   // hit and clear at the same edge
      rd("R6 hit beats clear", 2'd2, 8'h21);

      // R8 polarity toggles with steady pins
      tick(1'b1, 2'd2, 8'h00, 5'h0A);
      idle(4);
      tick(1'b1, 2'd2, 8'h00, 5'h0A);
      rd("R8 start clean", 2'd2, 8'h20);
      for (int k = 0; k < 6; k++)
         tick(1'b1, 2'd0, (k % 2 == 0) ? 8'h1F : 8'h00, 5'h0A);
      idle(3);
      rd("R8 no spurious flag", 2'd2, 8'h20);

      // random mix against the bench model (R4 R5 R7)
      for (int n = 0; n < 3000; n++) begin
         logic [1:0] ra;
         logic       w;
         logic [NP-1:0] p;
         ra = 2'($urandom_range(0, 3));
         rd("R4 random readback", ra, exp_read(ra));
         chk_irq("R7 random irq", exp_irq());
         w = ($urandom_range(0, 9) < 3);
         p = irq_pin;
         if ($urandom_range(0, 3) == 0) p = NP'($urandom);
         tick(w, 2'($urandom_range(0, 3)), 8'($urandom), p);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule